// File: doc/BRIEF.md
# Bit-Serial by Parallel Scaling Accumulator Multiplier

This block multiplies a parallel word by an operand that arrives one bit per clock, least significant bit first. A start pulse loads the parallel word and the signedness choice, and it clears the accumulator. For each serial bit that is accepted, the parallel word is gated by that bit and added into a registered sum. The sum's feedback path is shifted right by one position on every step, so the addend always enters at a fixed alignment. The bit that falls off the bottom of the sum is collected as a finished low product bit.

In signed mode, the partial product of the serial operand's top bit carries negative weight. The adder takes it away by inverting the sign-extended parallel word and forcing a carry-in. A parameter selects a narrower build that discards the finished low bits and exposes only the upper part of the product. Serial bits use a valid/ready handshake. Ready is high only while an operation is collecting bits, and not in a cycle where start is asserted. A bit offered while ready is low is not consumed, and the source keeps it. Start and done are plain control pins.

Top module: `spm_mul`

## Requirements
- R1: While reset is asserted and after it is released, `prod_o` is 0, `done_o` is 0 and `sbit_ready_o` is 0.
- R2: `sbit_ready_o` is 1 from the cycle after a start until exactly SW bits have been accepted, except in a cycle where `start_i` is 1. A bit is accepted when `sbit_valid_i` and `sbit_ready_o` are both 1.
- R3: With `signed_i`=0 at start, the final `prod_o` equals the unsigned product of `par_i` and the serial operand, taken modulo 2^(PW+SW). Bit i of the serial operand is the i-th accepted bit.
- R4: With `signed_i`=1 at start, both operands are two's complement and the final `prod_o` is their signed product in PW+SW bits.
- R5: `done_o` is 1 for exactly one cycle, in the cycle after the SW-th bit is accepted. In that cycle `prod_o` already holds the final product.
- R6: `prod_o` changes only in the cycle after a start or an accepted bit. After done it holds until the next start.
- R7: Bits offered while ready is low, and idle gaps between accepted bits, have no effect on the result.
- R8: A start during an operation abandons it. The next cycle shows `prod_o`=0, and a fresh operation begins.
- R9: With UPPER_ONLY=1, `prod_o` is PW bits wide. The final value equals bits [PW+SW-1:SW] of the full product.
- R10: The most negative operands (parallel 2^(PW-1) with serial 2^(SW-1), in signed mode) give exact results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clear and load; begins a new product |
| signed_i | input | 1 | Sampled at start: 1 selects two's complement operands |
| par_i | input | PW | Parallel operand, sampled at start |
| sbit_valid_i | input | 1 | Serial bit valid |
| sbit_i | input | 1 | Serial operand bit, LSB first |
| sbit_ready_o | output | 1 | Block can accept a serial bit |
| prod_o | output | OW | Product (PW+SW bits, or PW upper bits when UPPER_ONLY) |
| done_o | output | 1 | One-cycle strobe: product complete |

## Verification
The assertions take for granted that the inputs are never unknown after reset and that SW is at least 2, so two done strobes can never be adjacent. They also assume a start is a single decision per cycle: the operands sampled with it are whatever is on `par_i` and `signed_i` in that cycle. The stimulus drives every input a fixed delay after the falling edge and always applies a defined value, including garbage serial bits during gaps. It issues starts only as isolated one-cycle pulses, which keeps it inside these assumptions.

// File: rtl/spm_pkg.sv
package spm_pkg;
  // Action taken by the adder on one accepted serial bit.
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } op_e;
endpackage

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic signed_i,
  input  logic valid_i,
  input  logic bit_i,
  output logic ready_o,
  output logic step_o,
  output logic load_o,
  output logic sg_o,
  output logic done_o,
  output op_e  op_o
);
  localparam int CW = (SW > 1) ? $clog2(SW) : 1;
  localparam logic [CW-1:0] LAST = CW'(SW - 1);

  logic          busy_q;
  logic          sg_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last    = (cnt_q == LAST);
  assign ready_o = busy_q & ~start_i;
  assign step_o  = ready_o & valid_i;
  assign load_o  = start_i;
  assign sg_o    = sg_q;

  always_comb begin
    if (!step_o || !bit_i) op_o = OP_NONE;
    else if (sg_q && last)  op_o = OP_SUB;
    else                    op_o = OP_ADD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sg_q   <= 1'b0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      sg_q   <= signed_i;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= step_o & last;
      if (step_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spm_addsub.sv
module spm_addsub
  import spm_pkg::*;
#(
  parameter int PW = 24
) (
  input  logic [PW:0]   acc_i,
  input  logic [PW-1:0] par_i,
  input  logic          sg_i,
  input  op_e           op_i,
  output logic [PW+1:0] sum_o
);
  logic [PW+1:0] ext;
  logic [PW+1:0] addend;
  logic          cin;

  assign ext = {{2{sg_i & par_i[PW-1]}}, par_i};

  always_comb begin
    unique case (op_i)
      OP_ADD:  begin addend = ext;  cin = 1'b0; end
      OP_SUB:  begin addend = ~ext; cin = 1'b1; end
      default: begin addend = '0;   cin = 1'b0; end
    endcase
  end

  assign sum_o = {acc_i[PW], acc_i} + addend + {{(PW+1){1'b0}}, cin};
endmodule

// File: rtl/spm_mul.sv
module spm_mul
  import spm_pkg::*;
#(
  parameter int PW = 24,
  parameter int SW = 8,
  parameter bit UPPER_ONLY = 1'b0,
  localparam int OW = UPPER_ONLY ? PW : PW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          signed_i,
  input  logic [PW-1:0] par_i,
  input  logic          sbit_valid_i,
  input  logic          sbit_i,
  output logic          sbit_ready_o,
  output logic [OW-1:0] prod_o,
  output logic          done_o
);
  logic [PW-1:0] a_q;
  logic [PW:0]   h_q;
  logic [PW+1:0] sum;
  logic          step, load, sg;
  op_e           op;

  spm_ctrl #(.SW(SW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .valid_i(sbit_valid_i), .bit_i(sbit_i), .ready_o(sbit_ready_o),
    .step_o(step), .load_o(load), .sg_o(sg), .done_o(done_o), .op_o(op)
  );

  spm_addsub #(.PW(PW)) add_i (
    .acc_i(h_q), .par_i(a_q), .sg_i(sg), .op_i(op), .sum_o(sum)
  );

  // Upper accumulator: the feedback is the sum shifted right by one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      h_q <= '0;
    end else if (load) begin
      a_q <= par_i;
      h_q <= '0;
    end else if (step) begin
      h_q <= sum[PW+1:1];
    end
  end

  generate
    if (UPPER_ONLY) begin : g_upper
      assign prod_o = h_q[PW-1:0];
    end else begin : g_full
      logic [SW-1:0] l_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    l_q <= '0;
        else if (load) l_q <= '0;
        else if (step) l_q <= {sum[0], l_q[SW-1:1]};
      end
      assign prod_o = {h_q[PW-1:0], l_q};
    end
  endgenerate
endmodule

// File: rtl/spm_mul_chk.sv
module spm_mul_chk #(
  parameter int PW = 24,
  parameter int SW = 8,
  parameter int OW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          sbit_valid_i,
  input logic          sbit_ready_o,
  input logic [OW-1:0] prod_o,
  input logic          done_o
);
  localparam int KW = $clog2(SW + 1);
  localparam logic [KW-1:0] FULL = KW'(SW);

  logic [KW-1:0] taken_q;
  logic          acc;
  assign acc = sbit_valid_i & sbit_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       taken_q <= '0;
    else if (start_i) taken_q <= '0;
    else if (acc)     taken_q <= taken_q + 1'b1;
  end

  p_ready_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (sbit_ready_o || start_i));
  p_no_extra_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_q == FULL && !start_i) |-> !sbit_ready_o);
  p_done_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> taken_q == FULL);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !acc) |=> $stable(prod_o));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> prod_o == '0);
endmodule

bind spm_mul spm_mul_chk #(.PW(PW), .SW(SW), .OW(OW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .sbit_valid_i(sbit_valid_i),
  .sbit_ready_o(sbit_ready_o), .prod_o(prod_o), .done_o(done_o)
);

// File: tb/spm_mul_tb_top.sv
module spm_mul_tb_top;
  localparam int PW = 24;
  localparam int SW = 8;
  localparam int FW = PW + SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, sg = 1'b0, valid = 1'b0, sbit = 1'b0;
  logic [PW-1:0] par = '0;
  logic rdy, done, rdy_h, done_h;
  logic [FW-1:0] prod;
  logic [PW-1:0] prod_h;

  int checks = 0, failures = 0;
  string cur_tag = "R1";

  always #2 clk = ~clk;  // 250 MHz

  spm_mul #(.PW(PW), .SW(SW), .UPPER_ONLY(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .signed_i(sg), .par_i(par),
    .sbit_valid_i(valid), .sbit_i(sbit), .sbit_ready_o(rdy),
    .prod_o(prod), .done_o(done));

  spm_mul #(.PW(PW), .SW(SW), .UPPER_ONLY(1'b1)) dut_hi_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .signed_i(sg), .par_i(par),
    .sbit_valid_i(valid), .sbit_i(sbit), .sbit_ready_o(rdy_h),
    .prod_o(prod_h), .done_o(done_h));

  // Behavioural reference: running sum of weighted partial products.
  bit m_busy = 0, m_done = 0, m_sg = 0;
  int m_k = 0;
  longint m_part = 0;
  logic [PW-1:0] m_a = '0;
  logic [SW-1:0] m_b = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_k = 0; m_part = 0; m_b = '0;
    end else begin
      m_done = 0;
      if (start) begin
        m_busy = 1; m_k = 0; m_part = 0; m_a = par; m_sg = sg; m_b = '0;
      end else if (m_busy && valid) begin
        longint term;
        term = m_sg ? longint'($signed(m_a)) : longint'(m_a);
        if (sbit) begin
          if (m_sg && m_k == SW - 1) m_part = m_part - (term <<< m_k);
          else                       m_part = m_part + (term <<< m_k);
        end
        m_b[m_k] = sbit;
        m_k++;
        if (m_k == SW) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [63:0] e_full, e_up, ref_p;
    bit e_rdy;
    e_full = 64'(m_part <<< (SW - m_k));
    e_up   = 64'(m_part >>> m_k);
    e_rdy  = m_busy && !start;
    check(rdy == e_rdy, "R2 ready", longint'(rdy), longint'(e_rdy));
    check(done == m_done, "R5 done", longint'(done), longint'(m_done));
    check(prod == e_full[FW-1:0], "R6 product", longint'(prod), longint'(e_full[FW-1:0]));
    check(prod_h == e_up[PW-1:0], "R9 upper product", longint'(prod_h), longint'(e_up[PW-1:0]));
    check(done_h == m_done && rdy_h == e_rdy, "R9 upper handshake",
          longint'({done_h, rdy_h}), longint'({m_done, e_rdy}));
    if (m_done) begin
      ref_p = m_sg ? 64'(longint'($signed(m_a)) * longint'($signed(m_b)))
                   : 64'(longint'(m_a) * longint'(m_b));
      check(prod == ref_p[FW-1:0], "R3/R4/R5 final product",
            longint'(prod), longint'(ref_p[FW-1:0]));
      check(prod_h == ref_p[FW-1:SW], "R9 final upper", longint'(prod_h),
            longint'(ref_p[FW-1:SW]));
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic run(input logic [PW-1:0] a, input logic [SW-1:0] b, input bit s,
                     input int gap, input int stop_after);
    start = 1; par = a; sg = s; valid = 0;
    step();
    start = 0; par = ~a;
    for (int i = 0; i < SW; i++) begin
      if (i == stop_after) break;
      for (int g = 0; g < gap; g++) begin
        valid = 0; sbit = ~b[i];
        step();
      end
      valid = 1; sbit = b[i];
      step();
    end
    valid = 0;
    step();
  endtask

  initial begin
    cur_tag = "R1";
    valid = 1; sbit = 1;
    repeat (4) step();
    rst_n = 1;
    cur_tag = "R7";  // bits offered while idle are ignored
    repeat (3) step();
    valid = 0;
    cur_tag = "R3";
    run(24'hFFFFFF, 8'hFF, 0, 0, SW);
    run(24'h123456, 8'hA5, 0, 0, SW);
    run(24'h000001, 8'h01, 0, 0, SW);
    run(24'h000000, 8'hFF, 0, 0, SW);
    cur_tag = "R4/R10";
    run(24'h800000, 8'h80, 1, 0, SW);
    run(24'h800000, 8'h7F, 1, 0, SW);
    run(24'h7FFFFF, 8'h80, 1, 0, SW);
    run(24'hFFFFFF, 8'hFF, 1, 0, SW);
    run(24'h123456, 8'hC3, 1, 0, SW);
    cur_tag = "R7";
    run(24'hABCDEF, 8'h5A, 0, 2, SW);
    run(24'h876543, 8'h96, 1, 1, SW);
    cur_tag = "R8";
    run(24'h0F0F0F, 8'hFF, 1, 0, 3);
    run(24'h00F00F, 8'h81, 1, 0, SW);
    cur_tag = "R6";
    valid = 1; sbit = 1;
    repeat (5) step();
    valid = 0;
    repeat (2) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule